// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches the stream of temperature conversion results and raises an alert flag when the temperature crosses a pair of programmable limits. Each completed conversion is compared, as a signed two's-complement value, against a high limit and a low limit. A fault queue then demands a run of consecutive qualifying results before the alert changes, so a single noisy sample cannot toggle it.

Two alert behaviours are available. In thermostat (comparator) mode the flag follows the temperature with hysteresis: it sets at or above the high limit and releases below the low limit. In interrupt mode the flag latches until software reads any register or an alert-response acknowledge arrives. After each clear, the next event watched switches between the low and the high limit.

The limits are loaded and read back as byte pairs, most significant byte first. The packing is either 12-bit (normal) or 13-bit (extended). Entering shutdown, a general-call reset and changes to the mode or queue depth all act on the internal state as listed below. The polarity setting drives the physical pin.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset the high limit is 0x500 and the low limit is 0x4B0 (80 and 75 degrees at 0.0625 per LSB). In normal packing these read back as bytes 0x50,0x00 and 0x4B,0x00. The mode bit reads 0, the alert flag is 0, and the pin is 1.
- R2: Limit writes come in pairs of byte strobes, first byte then second byte. The limit selected with the second byte (1 = high, 0 = low) is updated only when that second byte arrives. In normal packing the value is the sign-extended 12-bit {first[7:0], second[7:4]}. Readback in normal packing gives first = value[11:4] and second = {value[3:0], 0000}.
- R3: In extended packing the value is {first[7:0], second[7:3]} and readback gives value[12:5] and {value[4:0], 000}. The temperature word is used as a full 13-bit signed value in extended packing. In normal packing only bits 11..0 of the temperature word are used, sign-extended from bit 11.
- R4: A conversion qualifies against the high limit when temperature >= high limit. It qualifies against the low limit when temperature < low limit. Both comparisons are signed.
- R5: The queue select 0,1,2,3 requires 1,2,4,6 consecutive qualifying conversions. A non-qualifying conversion restarts the count.
- R6: In comparator mode (mode bit 0), a clear flag sets after the required run at or above the high limit. A set flag clears after the required run below the low limit. Register reads and acknowledges have no effect on the flag in this mode.
- R7: In interrupt mode (mode bit 1), the flag sets after the required run against the armed limit. It stays set until a register-read or alert-response-acknowledge strobe, which clears it on the next cycle. Conversions arriving while the flag is set are not counted.
- R8: In interrupt mode, arming starts on the high limit and swaps between the high and low limit on every clear.
- R9: A rising edge of shutdown clears the flag, the fault count and the arming. Conversions are ignored while shutdown is high.
- R10: A general-call reset clears the flag, restores both limits and all configuration (mode 0, polarity 0, queue 0, normal packing) and discards a half-written limit.
- R11: With polarity 0 the pin is the inverse of the flag. With polarity 1 the pin equals the flag.
- R12: A configuration write that changes the mode bit or the queue select restarts the fault count and returns arming to the high limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is valid |
| conv_temp | input | 13 | Conversion result, signed, 0.0625 degree per LSB |
| cfg_wr | input | 1 | Load the configuration bits below |
| cfg_tm | input | 1 | Mode: 0 comparator, 1 interrupt |
| cfg_pol | input | 1 | Pin polarity: 0 active-low, 1 active-high |
| cfg_fq | input | 2 | Fault queue select |
| cfg_ext | input | 1 | 1 selects 13-bit extended packing |
| lim_wr_en | input | 1 | One limit byte is presented |
| lim_wr_sel | input | 1 | Limit targeted by the second byte: 1 high, 0 low |
| lim_wr_byte | input | 8 | Limit byte data |
| lim_rd_sel | input | 1 | Limit shown on readback: 1 high, 0 low |
| lim_rd_msb | output | 8 | First readback byte |
| lim_rd_lsb | output | 8 | Second readback byte |
| reg_rd | input | 1 | Strobe: some register was read |
| alert_resp_ack | input | 1 | Strobe: alert-response acknowledge succeeded |
| shutdown | input | 1 | Shutdown level |
| gen_call_rst | input | 1 | General-call reset strobe |
| alert_flag | output | 1 | Internal alert state, polarity-free |
| alert_pin | output | 1 | Physical alert level after polarity |
| mode_tm | output | 1 | Current mode bit |

## Verification
Errors in the hidden state show up only at the alert flag, and only some conversions later. A fault count that is off by one moves the set or clear by exactly one conversion against the bench's run length. A wrong arming phase in interrupt mode shows on the first conversion after a clear: a crossing of the wrong limit sets the flag, or a crossing of the right one does not. The reference model is compared with the flag, pin, mode bit and both readback bytes on every clock. A corrupted limit or half-written byte pair therefore shows on the readback in the cycle after the commit, whatever the temperature does.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int TEMP_W   = 13;
  localparam int NORM_W   = 12;
  localparam int BYTE_W   = 8;
  localparam int FQ_W     = 2;
  localparam int CNT_W    = 3;
  localparam int EXT_LOW  = TEMP_W - BYTE_W;
  localparam int NORM_LOW = NORM_W - BYTE_W;
  localparam int SEXT_W   = TEMP_W - NORM_W;

  typedef logic signed [TEMP_W-1:0] temp_t;

  typedef struct packed {
    logic            tm;
    logic            pol;
    logic [FQ_W-1:0] fq;
    logic            ext;
  } cfg_t;

  localparam cfg_t CFG_RST = '{tm: 1'b0, pol: 1'b0, fq: '0, ext: 1'b0};

  // consecutive-result run length for a queue select
  function automatic logic [CNT_W-1:0] fq_need(input logic [FQ_W-1:0] s);
    case (s)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction

  // temperature word as a signed value for the active packing
  function automatic temp_t as_temp(input logic [TEMP_W-1:0] raw, input logic ext);
    if (ext) return temp_t'(raw);
    return temp_t'({{SEXT_W{raw[NORM_W-1]}}, raw[NORM_W-1:0]});
  endfunction

  // assemble a limit from its byte pair
  function automatic temp_t join_bytes(input logic [BYTE_W-1:0] hi_b,
                                       input logic [BYTE_W-1:0] lo_b,
                                       input logic ext);
    if (ext) return temp_t'({hi_b, lo_b[BYTE_W-1 -: EXT_LOW]});
    return temp_t'({{SEXT_W{hi_b[BYTE_W-1]}}, hi_b, lo_b[BYTE_W-1 -: NORM_LOW]});
  endfunction

  function automatic logic [BYTE_W-1:0] first_byte(input temp_t v, input logic ext);
    return ext ? v[TEMP_W-1 -: BYTE_W] : v[NORM_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] second_byte(input temp_t v, input logic ext);
    if (ext) return {v[EXT_LOW-1:0], {(BYTE_W-EXT_LOW){1'b0}}};
    return {v[NORM_LOW-1:0], {(BYTE_W-NORM_LOW){1'b0}}};
  endfunction
endpackage

// File: rtl/tac_cfg_reg.sv
module tac_cfg_reg
  import tac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gcall,
  input  logic wr,
  input  cfg_t wr_data,
  output cfg_t cfg_q,
  output logic mode_chg
);
  // a write that alters mode or queue depth restarts counting (R12)
  assign mode_chg = wr && !gcall &&
                    ((wr_data.tm != cfg_q.tm) || (wr_data.fq != cfg_q.fq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= CFG_RST;
    else if (gcall) cfg_q <= CFG_RST;
    else if (wr)    cfg_q <= wr_data;
  end

  p_gcall_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gcall |=> !cfg_q.tm);
endmodule

// File: rtl/tac_limit_regs.sv
module tac_limit_regs
  import tac_pkg::*;
#(
  parameter int HI_RST = 1280,
  parameter int LO_RST = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gcall,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              ext,
  input  logic              rd_sel,
  output temp_t             hi_q,
  output temp_t             lo_q,
  output logic [BYTE_W-1:0] rd_msb,
  output logic [BYTE_W-1:0] rd_lsb
);
  localparam int NLIM = 2;

  logic [BYTE_W-1:0]             hold_q;
  logic                          phase_q;
  logic                          commit;
  logic [NLIM-1:0][TEMP_W-1:0]   lim_v;
  temp_t                         rd_val;

  assign commit = wr_en && phase_q && !gcall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else if (gcall) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else if (wr_en) begin
      phase_q <= !phase_q;
      if (!phase_q) hold_q <= wr_byte;
    end
  end

  // index 0 holds the low limit, index 1 the high limit
  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    localparam temp_t RST_V = temp_t'((i == 1) ? HI_RST : LO_RST);
    temp_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= RST_V;
      else if (gcall)                      q <= RST_V;
      else if (commit && wr_sel == 1'(i))  q <= join_bytes(hold_q, wr_byte, ext);
    end
    assign lim_v[i] = q;
  end

  assign hi_q   = temp_t'(lim_v[1]);
  assign lo_q   = temp_t'(lim_v[0]);
  assign rd_val = rd_sel ? hi_q : lo_q;
  assign rd_msb = first_byte(rd_val, ext);
  assign rd_lsb = second_byte(rd_val, ext);

  p_lim_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !gcall) |=> ($stable(hi_q) && $stable(lo_q)));
  p_first_byte_no_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !phase_q && !gcall) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/tac_fault_queue.sv
module tac_fault_queue
  import tac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             qual,
  input  logic [CNT_W-1:0] need,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = step && qual && !clr && (cnt_inc == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr)                    cnt_q <= '0;
    else if (step && (!qual || hit)) cnt_q <= '0;
    else if (step)                   cnt_q <= cnt_inc;
  end

  p_cnt_below_need_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < need);
  p_break_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !qual) |=> (cnt_q == '0));
endmodule

// File: rtl/tac_alert_core.sv
module tac_alert_core (
  input  logic clk,
  input  logic rst_n,
  input  logic gcall,
  input  logic tm,
  input  logic conv_done,
  input  logic shutdown,
  input  logic reg_rd,
  input  logic ack,
  input  logic mode_chg,
  input  logic ge_hi,
  input  logic lt_lo,
  input  logic hit,
  output logic fq_clr,
  output logic fq_step,
  output logic fq_qual,
  output logic alert_q
);
  logic sd_q;
  logic arm_lo_q;
  logic conv_evt;
  logic sd_rise;
  logic clr_req;

  assign conv_evt = conv_done && !shutdown;
  assign sd_rise  = shutdown && !sd_q;
  assign clr_req  = tm && alert_q && (reg_rd || ack);

  assign fq_clr  = gcall || sd_rise || mode_chg || clr_req;
  assign fq_step = conv_evt && !(tm && alert_q);
  assign fq_qual = tm ? (arm_lo_q ? lt_lo : ge_hi)
                      : (alert_q  ? lt_lo : ge_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= shutdown;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         alert_q <= 1'b0;
    else if (gcall || sd_rise || clr_req) alert_q <= 1'b0;
    else if (hit)                       alert_q <= tm ? 1'b1 : !alert_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            arm_lo_q <= 1'b0;
    else if (gcall || sd_rise || mode_chg) arm_lo_q <= 1'b0;
    else if (clr_req)                      arm_lo_q <= !arm_lo_q;
  end

  p_shutdown_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_rise |=> !alert_q);
  p_int_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !alert_q);
  p_gcall_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gcall |=> !alert_q);
  p_cmp_ignores_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tm && !conv_evt && !sd_rise && !gcall) |=> $stable(alert_q));
  p_arm_swaps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !gcall && !sd_rise && !mode_chg) |=> (arm_lo_q != $past(arm_lo_q)));
  p_rise_needs_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_q && !conv_evt) |=> !alert_q);
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tac_pkg::*;
#(
  parameter int HI_RST_CODE = 1280,
  parameter int LO_RST_CODE = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic              cfg_wr,
  input  logic              cfg_tm,
  input  logic              cfg_pol,
  input  logic [FQ_W-1:0]   cfg_fq,
  input  logic              cfg_ext,
  input  logic              lim_wr_en,
  input  logic              lim_wr_sel,
  input  logic [BYTE_W-1:0] lim_wr_byte,
  input  logic              lim_rd_sel,
  output logic [BYTE_W-1:0] lim_rd_msb,
  output logic [BYTE_W-1:0] lim_rd_lsb,
  input  logic              reg_rd,
  input  logic              alert_resp_ack,
  input  logic              shutdown,
  input  logic              gen_call_rst,
  output logic              alert_flag,
  output logic              alert_pin,
  output logic              mode_tm
);
  cfg_t  cfg_q;
  cfg_t  cfg_wdata;
  logic  mode_chg;
  temp_t hi_q;
  temp_t lo_q;
  temp_t temp_now;
  logic  ge_hi;
  logic  lt_lo;
  logic  fq_clr;
  logic  fq_step;
  logic  fq_qual;
  logic  fq_hit;

  assign cfg_wdata = '{tm: cfg_tm, pol: cfg_pol, fq: cfg_fq, ext: cfg_ext};

  tac_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .gcall    (gen_call_rst),
    .wr       (cfg_wr),
    .wr_data  (cfg_wdata),
    .cfg_q    (cfg_q),
    .mode_chg (mode_chg)
  );

  tac_limit_regs #(.HI_RST(HI_RST_CODE), .LO_RST(LO_RST_CODE)) u_lim (
    .clk     (clk),
    .rst_n   (rst_n),
    .gcall   (gen_call_rst),
    .wr_en   (lim_wr_en),
    .wr_sel  (lim_wr_sel),
    .wr_byte (lim_wr_byte),
    .ext     (cfg_q.ext),
    .rd_sel  (lim_rd_sel),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .rd_msb  (lim_rd_msb),
    .rd_lsb  (lim_rd_lsb)
  );

  assign temp_now = as_temp(conv_temp, cfg_q.ext);
  assign ge_hi    = temp_now >= hi_q;
  assign lt_lo    = temp_now <  lo_q;

  tac_fault_queue u_fq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fq_clr),
    .step  (fq_step),
    .qual  (fq_qual),
    .need  (fq_need(cfg_q.fq)),
    .hit   (fq_hit)
  );

  tac_alert_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .gcall     (gen_call_rst),
    .tm        (cfg_q.tm),
    .conv_done (conv_done),
    .shutdown  (shutdown),
    .reg_rd    (reg_rd),
    .ack       (alert_resp_ack),
    .mode_chg  (mode_chg),
    .ge_hi     (ge_hi),
    .lt_lo     (lt_lo),
    .hit       (fq_hit),
    .fq_clr    (fq_clr),
    .fq_step   (fq_step),
    .fq_qual   (fq_qual),
    .alert_q   (alert_flag)
  );

  assign alert_pin = cfg_q.pol ? alert_flag : !alert_flag;
  assign mode_tm   = cfg_q.tm;

  p_pin_polarity_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pin == alert_flag) == cfg_q.pol);
endmodule

// File: tb/temp_alert_ctrl_bench.sv
module temp_alert_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 0;
  logic [12:0] conv_temp = '0;
  logic        cfg_wr = 0, cfg_tm = 0, cfg_pol = 0, cfg_ext = 0;
  logic [1:0]  cfg_fq = '0;
  logic        lim_wr_en = 0, lim_wr_sel = 0, lim_rd_sel = 0;
  logic [7:0]  lim_wr_byte = '0;
  logic [7:0]  lim_rd_msb, lim_rd_lsb;
  logic        reg_rd = 0, alert_resp_ack = 0, shutdown = 0, gen_call_rst = 0;
  logic        alert_flag, alert_pin, mode_tm;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  temp_alert_ctrl u_temp_alert_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_temp(conv_temp),
    .cfg_wr(cfg_wr), .cfg_tm(cfg_tm), .cfg_pol(cfg_pol), .cfg_fq(cfg_fq),
    .cfg_ext(cfg_ext), .lim_wr_en(lim_wr_en), .lim_wr_sel(lim_wr_sel),
    .lim_wr_byte(lim_wr_byte), .lim_rd_sel(lim_rd_sel),
    .lim_rd_msb(lim_rd_msb), .lim_rd_lsb(lim_rd_lsb), .reg_rd(reg_rd),
    .alert_resp_ack(alert_resp_ack), .shutdown(shutdown),
    .gen_call_rst(gen_call_rst), .alert_flag(alert_flag),
    .alert_pin(alert_pin), .mode_tm(mode_tm)
  );

  always #5 clk = !clk;

  // ---------------- behavioural reference ----------------
  int m_hi, m_lo, m_tm, m_pol, m_fq, m_ext, m_alert, m_arm, m_cnt, m_ph, m_hold, m_sd;

  function automatic int need_of(int s);
    int tbl[4] = '{1, 2, 4, 6};
    return tbl[s];
  endfunction

  function automatic int temp_val(int raw, int ext);
    int v;
    if (ext != 0) begin v = raw % 8192; if (v >= 4096) v -= 8192; end
    else begin v = raw % 4096; if (v >= 2048) v -= 4096; end
    return v;
  endfunction

  function automatic int pair_val(int b1, int b2, int ext);
    int v;
    if (ext != 0) begin v = b1 * 32 + b2 / 8; if (v >= 4096) v -= 8192; end
    else begin v = b1 * 16 + b2 / 16; if (v >= 2048) v -= 4096; end
    return v;
  endfunction

  task automatic model_defaults();
    m_hi = 1280; m_lo = 1200; m_tm = 0; m_pol = 0; m_fq = 0; m_ext = 0;
    m_alert = 0; m_arm = 0; m_cnt = 0; m_ph = 0; m_hold = 0;
  endtask

  always @(posedge clk) begin
    int o_alert, o_tm, o_fq, o_ext, o_hi, o_lo, o_sd, chg, clr, t, q;
    if (!rst_n) begin
      model_defaults();
      m_sd = 0;
    end else begin
      o_alert = m_alert; o_tm = m_tm; o_fq = m_fq; o_ext = m_ext;
      o_hi = m_hi; o_lo = m_lo; o_sd = m_sd;
      m_sd = shutdown;
      if (gen_call_rst) model_defaults();
      else begin
        if (lim_wr_en) begin
          if (m_ph == 0) begin m_hold = lim_wr_byte; m_ph = 1; end
          else begin
            if (lim_wr_sel) m_hi = pair_val(m_hold, lim_wr_byte, o_ext);
            else            m_lo = pair_val(m_hold, lim_wr_byte, o_ext);
            m_ph = 0;
          end
        end
        chg = 0;
        if (cfg_wr) begin
          chg = (cfg_tm != o_tm) || (cfg_fq != o_fq);
          m_tm = cfg_tm; m_pol = cfg_pol; m_fq = cfg_fq; m_ext = cfg_ext;
        end
        clr = (o_tm == 1) && (o_alert == 1) && (reg_rd || alert_resp_ack);
        t = temp_val(conv_temp, o_ext);
        if (shutdown && o_sd == 0) begin
          m_alert = 0; m_cnt = 0; m_arm = 0;
        end else if (chg) begin
          m_cnt = 0; m_arm = 0;
          if (clr) m_alert = 0;
        end else if (clr) begin
          m_alert = 0; m_arm = 1 - m_arm; m_cnt = 0;
        end else if (conv_done && !shutdown && !(o_tm == 1 && o_alert == 1)) begin
          if (o_tm == 0) q = (o_alert == 1) ? (t < o_lo) : (t >= o_hi);
          else           q = (m_arm == 1)   ? (t < o_lo) : (t >= o_hi);
          if (q != 0) begin
            m_cnt++;
            if (m_cnt == need_of(o_fq)) begin
              m_cnt = 0;
              m_alert = (o_tm == 1) ? 1 : 1 - o_alert;
            end
          end else m_cnt = 0;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(posedge clk) begin
    int u, e_msb, e_lsb, e_pin;
    #2;
    if (rst_n && !done) begin
      u = (lim_rd_sel ? m_hi : m_lo);
      if (u < 0) u += 8192;
      if (m_ext != 0) begin e_msb = (u / 32) % 256; e_lsb = (u % 32) * 8; end
      else begin e_msb = (u / 16) % 256; e_lsb = (u % 16) * 16; end
      e_pin = (m_pol != 0) ? m_alert : 1 - m_alert;
      vectors++;
      if (alert_flag !== 1'(m_alert) || alert_pin !== 1'(e_pin) ||
          mode_tm !== 1'(m_tm) || lim_rd_msb !== 8'(e_msb) ||
          lim_rd_lsb !== 8'(e_lsb)) begin
        fails++;
        $display("FAIL %s t=%0t flag/pin/tm/msb/lsb actual %0b/%0b/%0b/%02h/%02h expected %0d/%0d/%0d/%02h/%02h",
                 cur_req, $time, alert_flag, alert_pin, mode_tm, lim_rd_msb, lim_rd_lsb,
                 m_alert, e_pin, m_tm, e_msb, e_lsb);
      end
    end
  end

  always @(negedge clk) lim_rd_sel <= !lim_rd_sel;

  // ---------------- stimulus tasks ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic conv(logic [12:0] t, int n = 1);
    repeat (n) begin
      @(negedge clk); conv_done = 1; conv_temp = t;
      @(negedge clk); conv_done = 0;
    end
  endtask

  task automatic write_lim(logic sel, logic [7:0] b1, logic [7:0] b2);
    @(negedge clk); lim_wr_en = 1; lim_wr_byte = b1; lim_wr_sel = sel;
    @(negedge clk); lim_wr_byte = b2;
    @(negedge clk); lim_wr_en = 0;
  endtask

  task automatic set_cfg(logic tm, logic pol, logic [1:0] fq, logic ext);
    @(negedge clk); cfg_wr = 1; cfg_tm = tm; cfg_pol = pol; cfg_fq = fq; cfg_ext = ext;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); reg_rd = 1; @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); alert_resp_ack = 1; @(negedge clk); alert_resp_ack = 0;
  endtask

  task automatic pulse_gcall();
    @(negedge clk); gen_call_rst = 1; @(negedge clk); gen_call_rst = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the sequence finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; idle(4);                       // reset limits, mode, pin
    cur_req = "R2";                                // byte-pair writes, normal packing
    write_lim(1'b0, 8'h4A, 8'h3F);
    write_lim(1'b1, 8'h5A, 8'h30);
    write_lim(1'b1, 8'h50, 8'h00);
    cur_req = "R6";                                // comparator hysteresis, one deep
    conv(13'h500); conv(13'h4A3);
    pulse_rd(); pulse_ack(); idle(2);
    conv(13'h4A2); idle(2);
    cur_req = "R5";                                // depth 4 then 6, run broken once
    set_cfg(0, 0, 2'd2, 0);
    conv(13'h600, 3); conv(13'h100); conv(13'h600, 3); idle(2); conv(13'h600);
    set_cfg(0, 0, 2'd3, 0);
    conv(13'h000, 5); conv(13'h600); conv(13'h000, 6); idle(2);
    cur_req = "R4";                                // negative limits, signed compare
    write_lim(1'b0, 8'hF6, 8'h00);
    write_lim(1'b1, 8'hFB, 8'h00);
    set_cfg(0, 0, 2'd0, 0);
    conv(13'h0FC0); conv(13'h0F60); conv(13'h0F50); idle(2);
    cur_req = "R11";                               // active-high pin
    set_cfg(0, 1, 2'd0, 0);
    conv(13'h0FC0); idle(3);
    cur_req = "R9";                                // shutdown clears and blocks
    @(negedge clk); shutdown = 1;
    conv(13'h0FC0, 2); idle(2);
    @(negedge clk); shutdown = 0; idle(2);
    cur_req = "R10";                               // general-call restore
    set_cfg(1, 1, 2'd1, 1);
    conv(13'h0FC0, 2); idle(2);
    @(negedge clk); lim_wr_en = 1; lim_wr_byte = 8'h11;
    @(negedge clk); lim_wr_en = 0;
    pulse_gcall(); idle(3);
    write_lim(1'b1, 8'h50, 8'h00); idle(2);
    cur_req = "R7";                                // latched interrupt
    set_cfg(1, 0, 2'd1, 0);
    conv(13'h500, 2); conv(13'h400); conv(13'h600); idle(2);
    pulse_rd(); idle(2);
    cur_req = "R8";                                // alternate arming
    conv(13'h600, 3); conv(13'h400, 2); idle(2);
    pulse_ack(); conv(13'h400, 2); conv(13'h500, 2); idle(2);
    pulse_rd(); idle(2);
    cur_req = "R12";                               // config change restarts
    set_cfg(1, 0, 2'd2, 0);
    conv(13'h500);
    set_cfg(1, 0, 2'd1, 0);
    conv(13'h500); idle(2); conv(13'h500); idle(2);
    pulse_rd();
    cur_req = "R3";                                // extended packing
    pulse_gcall();
    set_cfg(0, 0, 2'd0, 1); idle(3);
    write_lim(1'b1, 8'h96, 8'h08);
    conv(13'h12C1); conv(13'h1500); idle(2);
    set_cfg(0, 0, 2'd0, 0); idle(2);
    conv(13'h1500);
    write_lim(1'b1, 8'h50, 8'h00);
    conv(13'h1500); idle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule